// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers interrupt requests from up to sixteen peripheral sources into a sticky pending register and drives a single interrupt line toward the processor whenever a pending bit is also enabled. A separate enable register selects which pending bits may raise the line. Both registers sit on a small register bus and can be reached with half-word (16-bit) or word (32-bit) accesses.

A request is a source line held high for at least one clock edge. Level and single-cycle pulse requests are treated alike: each sets its pending bit, and the bit stays set after the source drops. Software clears pending bits by writing the pending register. The written data is combined by AND with the current pending and enable contents, so a 0 clears a bit and a 1 keeps it only if that bit is also enabled. Writing the enable register replaces it, and the line follows the new enable value on the very next edge.

Three source positions have fixed roles: bit 3 carries the DMA request, bit 7 the serial-port request and bit 9 the sound-unit request. The remaining positions are general purpose.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the pending register, the enable register and `irq_o` are all 0.
- R2: A source line high at a clock edge sets its pending bit at that edge. The bit stays set after the line returns low. Source lines 3 (DMA), 7 (serial port) and 9 (sound unit) set pending bits 3, 7 and 9.
- R3: A write to the pending register makes it pending & enable & wdata_i[15:0]. A 0 clears a bit, a 1 keeps an enabled bit, and bits that are not enabled are cleared.
- R4: When a source line is high in the same cycle as a pending write that would clear its bit, the bit stays set.
- R5: A write to the enable register replaces it with wdata_i[15:0]. If pending & new enable is nonzero, `irq_o` is 1 in the cycle after the write edge.
- R6: `irq_o` is a registered copy of the OR of pending & enable. It drops on the edge at which the last enabled pending bit is cleared.
- R7: The pending register is at byte offset 0x070 and the enable register at 0x074. A write to any other offset changes nothing, and a read there returns 0.
- R8: `size_i`=1 selects a word access and `size_i`=0 a half-word access. Both reach the registers at the same offsets, with data in bits 15:0. A word read returns the upper 16 bits as 0, and upper write data is ignored. A half-word access at offset 0x072 or 0x076 (the upper half) reads 0 and its writes are ignored.
- R9: Reads return the current register contents and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Peripheral request lines, one per pending bit |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 1 | 1 = word access, 0 = half-word access |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The collision that matters is a source request landing in the same cycle as a software acknowledge of that same bit. The bench forces this by driving the source line and a zeroing pending write between the same two edges. It expects the bit to read back as 1 and the line to stay high. A control run with the same write and no request expects the bit to clear and the line to drop. A second overlap, an enable write made while a bit is already pending, is judged by sampling `irq_o` just after the write edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // fixed roles of source positions
  localparam int unsigned SRC_DMA   = 3;
  localparam int unsigned SRC_SERIAL = 7;
  localparam int unsigned SRC_SOUND = 9;

  typedef enum logic {
    ACC_HALF = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode import irq_pkg::*; #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_SRC  = 16,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic               size_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               stat_we_o,
  output logic               mask_we_o,
  output logic [NUM_SRC-1:0] wr_data_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  acc_size_e  acc;
  logic       low_half;
  logic       hit_stat, hit_mask;
  logic [NUM_SRC-1:0] rsel;
  logic       unused_bits;

  assign acc      = acc_size_e'(size_i);
  // a half-word access to the upper half of a word reaches nothing
  assign low_half = (acc == ACC_WORD) || !addr_i[1];
  assign hit_stat = req_i && low_half && (addr_i[ADDR_W-1:2] == STAT_OFS[ADDR_W-1:2]);
  assign hit_mask = req_i && low_half && (addr_i[ADDR_W-1:2] == MASK_OFS[ADDR_W-1:2]);

  assign stat_we_o = hit_stat && we_i;
  assign mask_we_o = hit_mask && we_i;
  assign wr_data_o = wdata_i[NUM_SRC-1:0];

  always_comb begin
    rsel = '0;
    if (hit_stat && !we_i)      rsel = status_i;
    else if (hit_mask && !we_i) rsel = mask_i;
  end

  assign rdata_o     = {{(DATA_W-NUM_SRC){1'b0}}, rsel};
  assign unused_bits = ^{wdata_i[DATA_W-1:NUM_SRC], addr_i[0]};

  // R7
  always_comb r7_onehot_chk: assert ($onehot0({hit_stat, hit_mask}));
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               ack_we_i,
  input  logic [NUM_SRC-1:0] ack_data_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] status_q_o,
  output logic [NUM_SRC-1:0] status_d_o
);
  logic [NUM_SRC-1:0] status_q, status_d;

  // per-bit next state; a new request overrides an acknowledge
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    always_comb begin
      if (ack_we_i) status_d[b] = (status_q[b] & mask_i[b] & ack_data_i[b]) | src_i[b];
      else          status_d[b] = status_q[b] | src_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_q_o = status_q;
  assign status_d_o = status_d;

  // R2
  src_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != '0) |=> ((status_q & $past(src_i)) == $past(src_i)));
  // R3
  ack_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && src_i == '0) |=> (status_q == $past(status_q & mask_i & ack_data_i)));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_we_i && src_i == '0) |=> $stable(status_q));
endmodule

// File: rtl/irq_enable_gate.sv
module irq_enable_gate #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_data_i,
  input  logic [NUM_SRC-1:0] status_d_i,
  output logic [NUM_SRC-1:0] mask_q_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic               irq_q;

  assign mask_d = mask_we_i ? mask_data_i : mask_q;

  // evaluate on next-state values so a mask write shows on the following edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= |(status_d_i & mask_d);
    end
  end

  assign mask_q_o = mask_q;
  assign irq_o    = irq_q;

  // R5
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(mask_data_i)));
  // R9
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 16,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               size_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic               stat_we, mask_we;
  logic [NUM_SRC-1:0] wr_data, status_q, status_d, mask_q;

  irq_bus_decode #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .DATA_W(DATA_W),
    .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
  ) u_decode (
    .req_i(req_i), .we_i(we_i), .size_i(size_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .status_i(status_q), .mask_i(mask_q),
    .stat_we_o(stat_we), .mask_we_o(mask_we), .wr_data_o(wr_data),
    .rdata_o(rdata_o)
  );

  irq_pending_reg #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .ack_we_i(stat_we), .ack_data_i(wr_data), .mask_i(mask_q),
    .status_q_o(status_q), .status_d_o(status_d)
  );

  irq_enable_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .mask_we_i(mask_we),
    .mask_data_i(wr_data), .status_d_i(status_d),
    .mask_q_o(mask_q), .irq_o(irq_o)
  );

  // R6
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(status_q & mask_q));
  // R4
  src_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we && src_i != '0) |=> ((status_q & $past(src_i)) == $past(src_i)));
endmodule

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        req = 1'b0, we = 1'b0, size = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [11:0] A_STAT = 12'h070;
  localparam logic [11:0] A_MASK = 12'h074;

  always #2 clk = ~clk;

  irq_status_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .size_i(size), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic sz, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; size = sz; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic sz, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; size = sz; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] s);
    @(negedge clk); src = s;
    @(negedge clk); src = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(A_STAT, 1'b1, d); check("R1 status", d, 32'h0);
    rd(A_MASK, 1'b1, d); check("R1 mask", d, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_sources();
    logic [31:0] d;
    do_reset();
    pulse(16'h0008);                       // DMA
    rd(A_STAT, 1'b0, d); check("R2 dma sticky", d, 32'h0008);
    @(negedge clk); src = 16'h0280;        // serial + sound held as level
    repeat (3) @(negedge clk); src = '0;
    rd(A_STAT, 1'b1, d); check("R2 serial sound", d, 32'h0288);
    check("R2 irq stays low while disabled", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_ack_and();
    logic [31:0] d;
    do_reset();
    pulse(16'h0289);
    wr(A_MASK, 1'b1, 32'h0000_0288);
    check("R5 irq after enable", {31'h0, irq}, 32'h1);
    wr(A_STAT, 1'b0, 32'h0000_FF7F);       // clear bit 7; bit 0 is not enabled
    rd(A_STAT, 1'b1, d); check("R3 and result", d, 32'h0208);
    wr(A_STAT, 1'b1, 32'h0000_0000);
    rd(A_STAT, 1'b1, d); check("R3 clear all", d, 32'h0);
    check("R6 irq drops", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    do_reset();
    wr(A_MASK, 1'b1, 32'h8);
    pulse(16'h0008);
    @(negedge clk);
    req = 1'b1; we = 1'b1; size = 1'b1; addr = A_STAT; wdata = 32'h0; src = 16'h0008;
    @(negedge clk);
    req = 1'b0; we = 1'b0; src = '0;
    rd(A_STAT, 1'b1, d); check("R4 source wins", d, 32'h8);
    check("R4 irq held", {31'h0, irq}, 32'h1);
    wr(A_STAT, 1'b1, 32'h0);               // control: no request this time
    rd(A_STAT, 1'b1, d); check("R4 control clears", d, 32'h0);
    check("R6 control irq low", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_mask_timing();
    do_reset();
    pulse(16'h0080);
    check("R6 pending but disabled", {31'h0, irq}, 32'h0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; size = 1'b0; addr = A_MASK; wdata = 32'h80;
    @(posedge clk); #1;
    check("R5 irq next cycle", {31'h0, irq}, 32'h1);
    @(negedge clk); req = 1'b0; we = 1'b0;
    wr(A_MASK, 1'b0, 32'h0);
    check("R5 disable drops irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    do_reset();
    wr(A_MASK, 1'b1, 32'hFFFF_0003);
    rd(A_MASK, 1'b1, d); check("R8 upper ignored", d, 32'h0003);
    rd(A_MASK, 1'b0, d); check("R8 half read", d, 32'h0003);
    wr(12'h076, 1'b0, 32'h0000_FFFF);
    rd(A_MASK, 1'b1, d); check("R8 upper half write ignored", d, 32'h0003);
    rd(12'h072, 1'b0, d); check("R8 upper half read", d, 32'h0);
    pulse(16'h0003);
    wr(12'h078, 1'b1, 32'h0);
    rd(A_STAT, 1'b1, d); check("R7 other offset write", d, 32'h0003);
    wr(12'h000, 1'b1, 32'h0);
    rd(A_MASK, 1'b1, d); check("R7 mask untouched", d, 32'h0003);
    rd(12'h078, 1'b1, d); check("R7 other offset read", d, 32'h0);
    rd(A_STAT, 1'b1, d); check("R9 reread", d, 32'h0003);
    check("R9 irq unchanged", {31'h0, irq}, 32'h1);
  endtask

  initial begin
    t_reset();
    t_sources();
    t_ack_and();
    t_collision();
    t_mask_timing();
    t_decode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule